// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block collects up to 63 interrupt request lines, numbered 1 to 63, and shows a processor which one of them should be serviced next. Software programs it over a small register bus. Two 32-bit mask words gate the lines. A control byte for each line sets an interrupt level and a priority within that level. The controller checks every pending, unmasked line and registers two values: the winning level and a vector number. The vector number is a fixed base plus the number of the winning line.

Lines 1 to 7 are external lines with a fixed level. Each of them arbitrates at a level equal to its own line number, with a fixed mid-range priority. Their control bytes can still be written and read back. Lines 8 to 63 take their level and priority from their control bytes. Bit 0 of the low mask word is not a line mask: it is a global gate. It comes out of reset set, so nothing is presented until software clears it.

Top module: `intc_top`

## Requirements
- R1: Line n (1..31) is masked by bit n of the low mask word at byte address 0x08. Line n (32..63) is masked by bit n-32 of the high mask word at 0x0C. A 1 masks the line.
- R2: While bit 0 of the low mask word is 1, irq_level_o and irq_vec_o are both 0, whatever the lines and the other mask bits hold.
- R3: The control byte of line n is at byte address 0x40+n and is written from bus_wdata[7:0]. Bits [5:3] are the level and bits [2:0] the priority within the level.
- R4: A programmable line (8..63) whose control level is 0 never wins, even when it is pending and unmasked.
- R5: Among the eligible lines, the one with the highest level wins.
- R6: When levels are equal, the higher priority field wins. When level and priority are both equal, the lower line number wins.
- R7: irq_level_o gives the winning level and irq_vec_o gives VEC_BASE (default 64) plus the winning line number. With no winner, both are 0. The outputs are registered: they follow the inputs on the first rising edge after the arbitration inputs change.
- R8: Lines 1..7 arbitrate at level equal to their line number with priority 4, whatever their control byte holds. Their control byte still reads back what was written.
- R9: The mask words and the control bytes of lines 1..63 read back exactly what was written, including control bits [7:6]. The control address of line 0 and unmapped addresses read 0, and writes to them have no effect.
- R10: After reset the low mask word reads 0x00000001, the high mask word reads 0, and every control byte reads 0.
- R11: Input src_i[0] is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | 64 | Request lines; bit n is line n, bit 0 unused |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_level_o | output | 3 | Registered winning level, 0 = none |
| irq_vec_o | output | 8 | Registered vector number, 0 = none |

## Verification
A register write and a change on the request lines can fall in the same clock cycle. In that cycle the arbiter sees the new line state at once but the new mask only after the register edge. The bench provokes this by clearing the mask bit of a line while raising that line on the same cycle. It expects irq_level_o to stay 0 after the first edge and to show the line after the second. Fixed-rank lines that tie with programmed lines are also checked, to judge which source of rank data wins when both meet at one level.

// File: rtl/intc_pkg.sv
// Shared constants and the rank type for the interrupt controller.
package intc_pkg;
    localparam int LVL_W = 3;
    localparam int PRI_W = 3;
    localparam int CTL_W = 8;

    // Arbitration key: level is compared first, then priority.
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
    } rank_t;
endpackage

// File: rtl/intc_regs.sv
// Register file: two mask words and one control byte per line.
// Assumes N_SRC == 2*DATA_W and a control window that fits in the address space.
module intc_regs
    import intc_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int N_SRC        = 64,
    parameter int MASK_LO_ADDR = 8,
    parameter int MASK_HI_ADDR = 12,
    parameter int CTL_BASE     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] mask_lo_o,
    output logic [DATA_W-1:0] mask_hi_o,
    output logic [CTL_W-1:0]  ctl_o [N_SRC]
);
    localparam int IDX_W = $clog2(N_SRC);

    logic              wr_en;
    logic [ADDR_W-1:0] ctl_off;
    logic              ctl_hit;

    assign wr_en   = bus_sel && bus_wr;
    assign ctl_off = bus_addr - ADDR_W'(CTL_BASE);
    assign ctl_hit = (bus_addr >= ADDR_W'(CTL_BASE)) && (ctl_off < ADDR_W'(N_SRC));

    // Low mask word; bit 0 is the global gate and resets set.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_lo_o <= DATA_W'(1);
        else if (wr_en && bus_addr == ADDR_W'(MASK_LO_ADDR))
            mask_lo_o <= bus_wdata;
    end

    // High mask word for lines 32 and up.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_hi_o <= '0;
        else if (wr_en && bus_addr == ADDR_W'(MASK_HI_ADDR))
            mask_hi_o <= bus_wdata;
    end

    // One control byte per line; line 0 has none.
    for (genvar i = 0; i < N_SRC; i++) begin : g_ctl
        if (i == 0) begin : g_none
            assign ctl_o[i] = '0;
        end else begin : g_byte
            logic [CTL_W-1:0] ctl_q;
            // Hold the control byte of line i.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ctl_q <= '0;
                else if (wr_en && bus_addr == ADDR_W'(CTL_BASE + i))
                    ctl_q <= bus_wdata[CTL_W-1:0];
            end
            assign ctl_o[i] = ctl_q;
        end
    end

    // Read data selected by address; unmapped reads return zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(MASK_LO_ADDR))
            bus_rdata = mask_lo_o;
        else if (bus_addr == ADDR_W'(MASK_HI_ADDR))
            bus_rdata = mask_hi_o;
        else if (ctl_hit)
            bus_rdata = DATA_W'(ctl_o[ctl_off[IDX_W-1:0]]);
    end
endmodule

// File: rtl/intc_arbiter.sv
// Picks the strongest eligible line: level, then priority, then lowest number.
// Assumes req_i is already masked; lines 1..N_FIXED use a hardwired rank.
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int N_SRC     = 64,
    parameter int N_FIXED   = 7,
    parameter int FIXED_PRI = 4
) (
    input  logic [N_SRC-1:0]         req_i,
    input  logic [CTL_W-1:0]         ctl_i [N_SRC],
    output logic                     win_valid_o,
    output logic [LVL_W-1:0]         win_lvl_o,
    output logic [$clog2(N_SRC)-1:0] win_src_o
);
    localparam int IDX_W = $clog2(N_SRC);

    rank_t            rank [N_SRC];
    logic [N_SRC-1:0] elig;

    // Rank of each line, fixed or from its control byte.
    for (genvar i = 0; i < N_SRC; i++) begin : g_rank
        if (i >= 1 && i <= N_FIXED) begin : g_fixed
            assign rank[i] = '{lvl: LVL_W'(i), pri: PRI_W'(FIXED_PRI)};
        end else begin : g_prog
            assign rank[i] = '{lvl: ctl_i[i][PRI_W +: LVL_W], pri: ctl_i[i][PRI_W-1:0]};
        end
        assign elig[i] = (i != 0) && req_i[i] && (rank[i].lvl != '0);
    end

    // Linear scan; strict compare keeps the lower number on a full tie.
    always_comb begin
        rank_t best;
        best        = '0;
        win_valid_o = 1'b0;
        win_src_o   = '0;
        for (int i = 1; i < N_SRC; i++) begin
            if (elig[i] && rank[i] > best) begin
                best        = rank[i];
                win_valid_o = 1'b1;
                win_src_o   = IDX_W'(i);
            end
        end
        win_lvl_o = best.lvl;
    end
endmodule

// File: rtl/intc_present.sv
// Output stage: registers the winning level and vector number.
// Assumes VEC_BASE + N_SRC - 1 fits in VEC_W bits.
module intc_present
    import intc_pkg::*;
#(
    parameter int N_SRC    = 64,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     win_valid_i,
    input  logic [LVL_W-1:0]         win_lvl_i,
    input  logic [$clog2(N_SRC)-1:0] win_src_i,
    output logic [LVL_W-1:0]         irq_level_o,
    output logic [VEC_W-1:0]         irq_vec_o
);
    // Capture the arbitration result; idle shows zeros.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_level_o <= '0;
            irq_vec_o   <= '0;
        end else if (win_valid_i) begin
            irq_level_o <= win_lvl_i;
            irq_vec_o   <= VEC_W'(VEC_BASE) + VEC_W'(win_src_i);
        end else begin
            irq_level_o <= '0;
            irq_vec_o   <= '0;
        end
    end
endmodule

// File: rtl/intc_top.sv
// Interrupt controller top: registers, mask gating, arbitration, output stage.
// Assumes two mask words cover all lines (N_SRC == 2*DATA_W).
module intc_top
    import intc_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int ADDR_W       = 8,
    parameter int N_FIXED      = 7,
    parameter int FIXED_PRI    = 4,
    parameter int VEC_W        = 8,
    parameter int VEC_BASE     = 64,
    parameter int MASK_LO_ADDR = 8,
    parameter int MASK_HI_ADDR = 12,
    parameter int CTL_BASE     = 64
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*DATA_W-1:0]   src_i,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [LVL_W-1:0]      irq_level_o,
    output logic [VEC_W-1:0]      irq_vec_o
);
    localparam int N_SRC = 2 * DATA_W;
    localparam int IDX_W = $clog2(N_SRC);

    logic [DATA_W-1:0] mask_lo_q;
    logic [DATA_W-1:0] mask_hi_q;
    logic [CTL_W-1:0]  ctl_q [N_SRC];
    logic [N_SRC-1:0]  line_mask;
    logic [N_SRC-1:0]  req;
    logic              win_valid;
    logic [LVL_W-1:0]  win_lvl;
    logic [IDX_W-1:0]  win_src;

    intc_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_SRC(N_SRC),
        .MASK_LO_ADDR(MASK_LO_ADDR), .MASK_HI_ADDR(MASK_HI_ADDR), .CTL_BASE(CTL_BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mask_lo_o(mask_lo_q), .mask_hi_o(mask_hi_q), .ctl_o(ctl_q)
    );

    // Per-line mask vector; bit 0 of the low word does not mask line 0 but gates all.
    assign line_mask = {mask_hi_q, mask_lo_q[DATA_W-1:1], 1'b1};

    // Pending and unmasked lines, cleared entirely by the global gate.
    assign req = mask_lo_q[0] ? '0 : (src_i & ~line_mask);

    intc_arbiter #(
        .N_SRC(N_SRC), .N_FIXED(N_FIXED), .FIXED_PRI(FIXED_PRI)
    ) u_arb (
        .req_i(req), .ctl_i(ctl_q),
        .win_valid_o(win_valid), .win_lvl_o(win_lvl), .win_src_o(win_src)
    );

    intc_present #(
        .N_SRC(N_SRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
    ) u_out (
        .clk(clk), .rst_n(rst_n),
        .win_valid_i(win_valid), .win_lvl_i(win_lvl), .win_src_i(win_src),
        .irq_level_o(irq_level_o), .irq_vec_o(irq_vec_o)
    );
endmodule

// File: rtl/intc_checker.sv
// Protocol checks on the controller outputs against its inputs and mask state.
module intc_checker #(
    parameter int N_SRC    = 64,
    parameter int DATA_W   = 32,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_i,
    input logic [DATA_W-1:0] mask_lo,
    input logic [DATA_W-1:0] mask_hi,
    input logic [2:0]        irq_level_o,
    input logic [VEC_W-1:0]  irq_vec_o
);
    localparam int IDX_W = $clog2(N_SRC);

    logic [N_SRC-1:0] src_d;
    logic [N_SRC-1:0] mask_d;
    logic [VEC_W-1:0] off;
    logic [IDX_W-1:0] idx;

    // Inputs as the output stage saw them one edge ago.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_d  <= '0;
            mask_d <= '1;
        end else begin
            src_d  <= src_i;
            mask_d <= {mask_hi, mask_lo};
        end
    end

    assign off = irq_vec_o - VEC_W'(VEC_BASE);
    assign idx = off[IDX_W-1:0];

    p_maskall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mask_lo[0] |=> irq_level_o == 3'd0);

    p_idle_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o == 3'd0 |-> irq_vec_o == '0);

    p_vec_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o != 3'd0 |-> (irq_vec_o > VEC_W'(VEC_BASE)) &&
                                (irq_vec_o < VEC_W'(VEC_BASE + N_SRC)));

    p_winner_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o != 3'd0 |-> src_d[idx] && idx != '0);

    p_winner_unmasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        irq_level_o != 3'd0 |-> !mask_d[idx] && !mask_d[0]);
endmodule

bind intc_top intc_checker #(
    .N_SRC(N_SRC), .DATA_W(DATA_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .mask_lo(mask_lo_q), .mask_hi(mask_hi_q),
    .irq_level_o(irq_level_o), .irq_vec_o(irq_vec_o)
);

// File: tb/test_intc_top.sv
// Directed bench for intc_top: one task per scenario.
module test_intc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] src_i = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  irq_level_o;
    logic [7:0]  irq_vec_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_LO  = 8'h08;
    localparam logic [7:0] A_HI  = 8'h0C;
    localparam logic [7:0] A_CTL = 8'h40;

    always #5 clk = ~clk;

    intc_top i_intc_top (
        .clk(clk), .rst_n(rst_n), .src_i(src_i),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_level_o(irq_level_o), .irq_vec_o(irq_vec_o)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic drive(logic [63:0] s);
        @(negedge clk);
        src_i = s;
    endtask

    // Two edges pass: register update plus output register.
    task automatic expect_out(string tag, int lvl, int vec);
        @(negedge clk);
        @(negedge clk);
        chk({tag, " level"}, irq_level_o, lvl);
        chk({tag, " vector"}, irq_vec_o, vec);
    endtask

    function automatic logic [63:0] bit_of(int n);
        return 64'd1 << n;
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(A_LO, d);       chk("R10 mask lo reset", d, 1);
        rd(A_HI, d);       chk("R10 mask hi reset", d, 0);
        rd(A_CTL + 20, d); chk("R10 ctl reset", d, 0);
        drive('1);
        expect_out("R2 gate after reset", 0, 0);
        drive('0);
        wr(A_LO, 0);
    endtask

    task automatic t_level_zero();
        drive(bit_of(20));
        expect_out("R4 unconfigured", 0, 0);
        wr(A_CTL + 20, 32'h07);
        expect_out("R4 level zero prio seven", 0, 0);
    endtask

    task automatic t_levels();
        wr(A_CTL + 20, 32'h19);
        wr(A_CTL + 40, 32'h28);
        drive(bit_of(20));
        expect_out("R3 single line", 3, 84);
        drive(bit_of(20) | bit_of(40));
        expect_out("R5 higher level", 5, 104);
    endtask

    task automatic t_priority();
        wr(A_CTL + 21, 32'h2E);
        drive(bit_of(20) | bit_of(21) | bit_of(40));
        expect_out("R6 higher prio", 5, 85);
        wr(A_CTL + 45, 32'h2E);
        drive(bit_of(21) | bit_of(45));
        expect_out("R6 full tie lower number", 5, 85);
    endtask

    task automatic t_mask_map();
        wr(A_HI, 32'h0000_2000);
        drive(bit_of(45));
        expect_out("R1 high word bit 13", 0, 0);
        drive(bit_of(21) | bit_of(45));
        expect_out("R1 high mask leaves 21", 5, 85);
        wr(A_HI, 0);
        wr(A_LO, 32'h0020_0000);
        expect_out("R1 low word bit 21", 5, 109);
        wr(A_LO, 32'h0000_0001);
        expect_out("R2 global gate", 0, 0);
        wr(A_LO, 0);
        expect_out("R2 gate released", 5, 85);
    endtask

    task automatic t_fixed();
        logic [31:0] d;
        wr(A_CTL + 3, 32'h3F);
        drive(bit_of(3));
        expect_out("R8 fixed line level", 3, 67);
        rd(A_CTL + 3, d); chk("R8 fixed ctl readback", d, 32'h3F);
        drive(bit_of(3) | bit_of(40));
        expect_out("R8 fixed loses to level 5", 5, 104);
        wr(A_CTL + 30, 32'h2C);
        drive(bit_of(5) | bit_of(30));
        expect_out("R8 fixed wins tie", 5, 69);
        wr(A_CTL + 30, 32'h2D);
        expect_out("R8 higher prio beats fixed", 5, 94);
    endtask

    task automatic t_src0();
        drive(bit_of(0));
        expect_out("R11 line 0 ignored", 0, 0);
    endtask

    task automatic t_readback();
        logic [31:0] d;
        wr(A_HI, 32'hA5A5_5A5A);
        rd(A_HI, d);       chk("R9 mask hi readback", d, 32'hA5A5_5A5A);
        wr(A_CTL + 63, 32'hC9);
        rd(A_CTL + 63, d); chk("R9 ctl upper bits kept", d, 32'hC9);
        wr(A_CTL, 32'hFF);
        rd(A_CTL, d);      chk("R9 line 0 ctl reads 0", d, 0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, d);      chk("R9 unmapped reads 0", d, 0);
        rd(A_LO, d);       chk("R9 unmapped write no effect", d, 0);
        wr(A_HI, 0);
    endtask

    task automatic t_timing();
        drive('0);
        expect_out("R7 idle", 0, 0);
        @(negedge clk);
        src_i = bit_of(40);
        #1 chk("R7 held before edge", irq_vec_o, 0);
        @(negedge clk);
        chk("R7 one edge later level", irq_level_o, 5);
        chk("R7 one edge later vector", irq_vec_o, 104);
    endtask

    task automatic t_same_cycle();
        wr(A_HI, 32'h0000_0100);
        drive('0);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = A_HI; bus_wdata = 0;
        src_i = bit_of(40);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        chk("R1 old mask at first edge", irq_level_o, 0);
        @(negedge clk);
        chk("R1 new mask at second edge", irq_vec_o, 104);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_level_zero();
        t_levels();
        t_priority();
        t_mask_map();
        t_fixed();
        t_src0();
        t_readback();
        t_timing();
        t_same_cycle();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule